// File: doc/BRIEF.md
# I2C Target Byte Engine with Bounded Clock Stretching

This block is the bus-facing half of an I2C target. It samples the SCL and SDA lines through a synchronizer on the system clock and pulls either line low through open-drain enables. It detects start, repeated start and stop conditions. It compares the address byte of each transfer with a programmable 7-bit address, acknowledges matching address bytes and every byte written to it, and shifts data in and out MSB first. Command meaning belongs to the core logic behind it.

The core sees two valid/ready streams. Every received byte, including the address byte of a write transfer, is offered on the receive stream. The target asks for each byte it has to transmit by raising `tx_ready` on the transmit stream. The bus is held still while the core is slow. After a matching address byte, after each received byte, and after each transmitted byte that the master acknowledges, the target holds SCL low. It releases SCL only when the pending handshake has completed and a programmable minimum number of system clock cycles has passed. There is at most one such stretch per byte, and there is none after the final, NACKed byte of a read.

Back-pressure rules: once `rx_valid` is high, `rx_data` and `rx_first` stay unchanged until a cycle with `rx_ready` high. Once `tx_ready` is high, it stays high until a cycle with `tx_valid` high, and `tx_data` is taken in that cycle. A handshake is a rising clock edge with both signals of a stream high.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: A start condition is SDA falling while SCL is high. It abandons any partial byte and begins a new address byte, including as a repeated start without a stop. A stop condition is SDA rising while SCL is high. It returns the target to idle with both enables released.
- R2: Bits are sampled MSB first on SCL rising edges. In the address byte, bits 7:1 are the address and bit 0 is the direction (0 = write, 1 = read). When bits 7:1 equal `own_addr`, the target pulls SDA low through the 9th (ACK) clock.
- R3: A non-matching address byte gets no ACK, no stretch and no receive item. All following bytes are ignored in the same way until the next start condition.
- R4: In a write transfer, the target ACKs every byte. It offers the address byte with `rx_first`=1, then each data byte with `rx_first`=0, with `rx_data` holding the byte as it was sent.
- R5: SCL is stretched exactly once after a matching address byte and once after every received data byte. In a read, it is stretched once after each transmitted byte that the master ACKs, and never after a byte that the master NACKs. There is never more than one stretch between two SCL rising edges.
- R6: Every stretch keeps `scl_oe` high for at least `min_stretch` system clock cycles, even when the core is ready at once.
- R7: A stretch does not end before the pending handshake completes. That is the receive item for a write address or data byte, and the transmit byte for a read address or an ACKed read byte.
- R8: In a read, the first byte is fetched during the address stretch and each further byte during the stretch after the previous ACK. Each byte is driven on SDA MSB first, with `sda_oe`=1 for a 0 bit.
- R9: `rx_valid` with stable `rx_data` is held until accepted, and `tx_ready` is held until `tx_valid`.
- R10: After reset, `scl_oe`, `sda_oe`, `rx_valid` and `tx_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address this target answers to |
| min_stretch | input | STR_W | Minimum stretch length in system clock cycles |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or 0 data bit) |
| rx_valid | output | 1 | A received byte is offered |
| rx_ready | input | 1 | Core accepts the received byte |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Offered byte is the address byte of a write |
| tx_ready | output | 1 | Target requests the next byte to transmit |
| tx_valid | input | 1 | Core presents a byte to transmit |
| tx_data | input | 8 | Byte to transmit |

## Verification
A bench-side master drives open-drain SCL and SDA against the target, and a core model answers both streams after a chosen latency. Writes and reads are run with and without a matching address, so ACK and stretch behaviour on a match can be told apart from silent ignoring. Each run is tried with a zero minimum and zero latency, with a long minimum against a core that is ready at once, and with a slow core against a short minimum. These show which of the two gates sets the stretch length. Further runs use a repeated start after a write phase, a start that cuts a byte short, and random transfers with random data, lengths, minimums and latencies. These separate the per-byte stretch count and the NACK-terminated read from ordinary traffic.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_RECV,
    EN_HOLD,
    EN_ACK_LO,
    EN_ACK_HI,
    EN_SEND,
    EN_MACK,
    EN_SKIP
  } eng_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_stretch_tmr.sv
module i2c_tgt_stretch_tmr #(
  parameter int STR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [STR_W-1:0] min_len,
  output logic             done
);
  logic [STR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != {STR_W{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= min_len);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              tmr_done,
  output logic              hold_scl,
  output logic              drv_sda,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              tx_ready,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data
);
  eng_state_e           state;
  logic [BIT_CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0]    shreg;
  logic [BYTE_W-1:0]    txsh;
  logic                 is_addr;
  logic                 rd_mode;
  logic                 hs_done;
  logic                 str_ack;
  logic                 mack;
  logic                 byte_done;
  logic                 addr_hit;

  assign byte_done = (bitcnt == BIT_CNT_W'(BYTE_W));
  assign addr_hit  = (shreg[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= EN_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      hs_done  <= 1'b0;
      str_ack  <= 1'b0;
      mack     <= 1'b0;
      hold_scl <= 1'b0;
      drv_sda  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
      tx_ready <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        hs_done  <= 1'b1;
      end
      if (tx_ready && tx_valid) begin
        tx_ready <= 1'b0;
        hs_done  <= 1'b1;
        txsh     <= tx_data;
        if (!str_ack) drv_sda <= ~tx_data[BYTE_W-1];
      end

      if (start_det && state != EN_HOLD) begin
        state    <= EN_RECV;
        bitcnt   <= '0;
        is_addr  <= 1'b1;
        drv_sda  <= 1'b0;
        hold_scl <= 1'b0;
      end else if (stop_det && state != EN_HOLD) begin
        state    <= EN_IDLE;
        drv_sda  <= 1'b0;
        hold_scl <= 1'b0;
      end else begin
        unique case (state)
          EN_IDLE: ;
          EN_RECV: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              if (is_addr && !addr_hit) begin
                state <= EN_SKIP;
              end else begin
                state    <= EN_HOLD;
                hold_scl <= 1'b1;
                drv_sda  <= 1'b1;
                str_ack  <= 1'b1;
                hs_done  <= 1'b0;
                if (is_addr) rd_mode <= shreg[0];
                if (is_addr && shreg[0]) begin
                  tx_ready <= 1'b1;
                end else begin
                  rx_valid <= 1'b1;
                  rx_data  <= shreg;
                  rx_first <= is_addr;
                end
              end
            end
          end
          EN_HOLD: begin
            if (hs_done && tmr_done) begin
              hold_scl <= 1'b0;
              if (str_ack) begin
                state <= EN_ACK_LO;
              end else begin
                state  <= EN_SEND;
                bitcnt <= '0;
              end
            end
          end
          EN_ACK_LO: if (scl_rise) state <= EN_ACK_HI;
          EN_ACK_HI: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                drv_sda <= ~txsh[BYTE_W-1];
                state   <= EN_SEND;
              end else begin
                drv_sda <= 1'b0;
                is_addr <= 1'b0;
                state   <= EN_RECV;
              end
            end
          end
          EN_SEND: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                drv_sda <= 1'b0;
                state   <= EN_MACK;
              end else begin
                txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                drv_sda <= ~txsh[BYTE_W-2];
              end
            end
          end
          EN_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state    <= EN_HOLD;
                hold_scl <= 1'b1;
                str_ack  <= 1'b0;
                hs_done  <= 1'b0;
                tx_ready <= 1'b1;
              end else begin
                state <= EN_SKIP;
              end
            end
          end
          EN_SKIP: ;
          default: state <= EN_IDLE;
        endcase
      end
    end
  end

  logic       hold_d;
  logic [1:0] str_per_bit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d      <= 1'b0;
      str_per_bit <= '0;
    end else begin
      hold_d <= hold_scl;
      if (scl_rise) str_per_bit <= '0;
      else if (hold_scl && !hold_d && str_per_bit != 2'b11) str_per_bit <= str_per_bit + 1'b1;
    end
  end

  AST_ONE_STRETCH_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    str_per_bit <= 2'd1); // R5
  AST_STRETCH_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_scl) |-> !scl_s); // R5
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_first))); // R9
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ready); // R9
  AST_RELEASE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_scl) |-> (!rx_valid && !tx_ready)); // R7
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int STR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [STR_W-1:0]  min_stretch,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              tx_ready,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic tmr_done, hold_scl, drv_sda;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_stretch_tmr #(.STR_W(STR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(hold_scl), .min_len(min_stretch), .done(tmr_done)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tmr_done(tmr_done),
    .hold_scl(hold_scl), .drv_sda(drv_sda),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_first(rx_first),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign scl_oe = hold_scl;
  assign sda_oe = drv_sda;

  logic [STR_W:0] hold_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_len <= '0;
    else if (!hold_scl) hold_len <= '0;
    else if (!(&hold_len)) hold_len <= hold_len + 1'b1;
  end

  AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_scl) |-> (hold_len >= {1'b0, min_stretch})); // R6
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R1
endmodule

// File: tb/tb_i2c_tgt_stretch.sv
module tb_i2c_tgt_stretch;
  localparam int STR_W = 16;
  localparam int LO = 12;
  localparam int HI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [6:0]       own_addr = 7'h0E;
  logic [STR_W-1:0] min_stretch = '0;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_oe, sda_oe, rx_valid, rx_first, tx_ready;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic scl_line, sda_line;
  assign scl_line = !(m_scl_lo || scl_oe);
  assign sda_line = !(m_sda_lo || sda_oe);

  i2c_tgt_stretch #(.STR_W(STR_W)) dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .min_stretch(min_stretch),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_first(rx_first),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // core model
  int core_lat = 0;
  int rx_wait = 0, tx_wait = 0;
  int rx_n = 0, tx_n = 0;
  logic [8:0] rx_log [0:63];
  logic [7:0] tx_src [0:15];
  logic [7:0] wr_buf [0:15];
  initial forever begin
    @(negedge clk);
    rx_ready = 1'b0;
    tx_valid = 1'b0;
    if (rx_valid) begin
      if (rx_wait > 0) rx_wait--;
      else begin
        rx_ready = 1'b1;
        rx_log[rx_n % 64] = {rx_first, rx_data};
        rx_n++;
        rx_wait = core_lat;
      end
    end
    if (tx_ready) begin
      if (tx_wait > 0) tx_wait--;
      else begin
        tx_valid = 1'b1;
        tx_data = tx_src[tx_n % 16];
        tx_n++;
        tx_wait = core_lat;
      end
    end
  end

  // stretch and back-pressure monitor
  int run_len = 0, n_str = 0, bp_viol = 0;
  int str_len [0:63];
  logic p_rxv = 1'b0, p_txr = 1'b0;
  logic [7:0] p_rxd = 8'h00;
  always @(posedge clk) begin
    #1;
    if (scl_oe) run_len++;
    else if (run_len > 0) begin
      str_len[n_str % 64] = run_len;
      n_str++;
      run_len = 0;
    end
    if (p_rxv && !rx_ready && (!rx_valid || rx_data != p_rxd)) bp_viol++;
    if (p_txr && !tx_valid && !tx_ready) bp_viol++;
    p_rxv = rx_valid;
    p_rxd = rx_data;
    p_txr = tx_ready;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic scl_up();
    m_scl_lo = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask
  task automatic m_start();
    m_sda_lo = 1'b0; wait_cyc(LO);
    scl_up(); wait_cyc(HI);
    m_sda_lo = 1'b1; wait_cyc(HI);
    m_scl_lo = 1'b1;
  endtask
  task automatic m_stop();
    m_sda_lo = 1'b1; wait_cyc(LO);
    scl_up(); wait_cyc(HI);
    m_sda_lo = 1'b0; wait_cyc(HI);
  endtask
  task automatic m_wbit(input logic b);
    m_sda_lo = !b; wait_cyc(LO);
    scl_up(); wait_cyc(HI);
    m_scl_lo = 1'b1;
  endtask
  task automatic m_rbit(output logic b);
    m_sda_lo = 1'b0; wait_cyc(LO);
    scl_up(); wait_cyc(HI/2);
    b = sda_line; wait_cyc(HI - HI/2);
    m_scl_lo = 1'b1;
  endtask
  task automatic m_wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(nack);
  endtask
  task automatic m_rbyte(output logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) m_rbit(d[i]);
    m_wbit(ack ? 1'b0 : 1'b1);
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check_lens(input int s0, input int cnt, input string req);
    int lo;
    lo = maxi(int'(min_stretch), core_lat);
    for (int i = s0; i < s0 + cnt; i++) begin
      chk(str_len[i % 64] >= lo, req, "stretch length lower bound", str_len[i % 64], lo);
      chk(str_len[i % 64] <= lo + 6, req, "stretch length upper bound", str_len[i % 64], lo + 6);
    end
  endtask

  // write transfer: address a, n bytes from wr_buf
  task automatic run_write(input logic [6:0] a, input int n, input bit do_stop);
    logic nk;
    int s0, nacks;
    bit hit;
    hit = (a == own_addr);
    s0 = n_str; rx_n = 0; rx_wait = core_lat; nacks = 0;
    m_start();
    m_wbyte({a, 1'b0}, nk);
    chk(nk == !hit, hit ? "R2" : "R3", "address ack bit", nk, !hit);
    for (int i = 0; i < n; i++) begin
      m_wbyte(wr_buf[i], nk);
      if (nk) nacks++;
    end
    if (do_stop) m_stop();
    wait_cyc(8);
    chk(nacks == (hit ? 0 : n), hit ? "R4" : "R3", "data nacks", nacks, hit ? 0 : n);
    chk(n_str - s0 == (hit ? n + 1 : 0), hit ? "R5" : "R3", "write stretches", n_str - s0, hit ? n + 1 : 0);
    chk(rx_n == (hit ? n + 1 : 0), hit ? "R4" : "R3", "rx items", rx_n, hit ? n + 1 : 0);
    if (hit && rx_n == n + 1) begin
      chk(rx_log[0] == {1'b1, a, 1'b0}, "R4", "address item", rx_log[0], {1'b1, a, 1'b0});
      for (int i = 0; i < n; i++)
        chk(rx_log[i+1] == {1'b0, wr_buf[i]}, "R4", "data item", rx_log[i+1], {1'b0, wr_buf[i]});
      check_lens(s0, n + 1, "R6");
    end
  endtask

  // read transfer: n bytes, last one NACKed
  task automatic run_read(input logic [6:0] a, input int n);
    logic nk;
    logic [7:0] d;
    int s0, bad;
    bit hit;
    hit = (a == own_addr);
    s0 = n_str; tx_n = 0; tx_wait = core_lat; bad = 0;
    m_start();
    m_wbyte({a, 1'b1}, nk);
    chk(nk == !hit, hit ? "R2" : "R3", "read address ack bit", nk, !hit);
    if (hit) begin
      for (int i = 0; i < n; i++) begin
        m_rbyte(d, i < n - 1);
        chk(d == tx_src[i], "R8", "read byte", d, tx_src[i]);
      end
    end
    m_stop();
    wait_cyc(8);
    chk(n_str - s0 == (hit ? n : 0), hit ? "R5" : "R3", "read stretches", n_str - s0, hit ? n : 0);
    chk(tx_n == (hit ? n : 0), "R8", "bytes fetched", tx_n, hit ? n : 0);
    if (hit) check_lens(s0, n, "R7");
  endtask

  initial begin
    logic dummy;
    int r;
    r = $urandom(32'd20240611);
    wait_cyc(10);
    chk(!scl_oe && !sda_oe && !rx_valid && !tx_ready, "R10", "outputs in reset",
        {scl_oe, sda_oe, rx_valid, tx_ready}, 0);
    rst_n = 1'b1;
    wait_cyc(10);
    chk(!scl_oe && !sda_oe && !rx_valid && !tx_ready, "R10", "outputs after reset",
        {scl_oe, sda_oe, rx_valid, tx_ready}, 0);

    // R2 R4 R5: basic write, fast core
    wr_buf[0] = 8'h94; wr_buf[1] = 8'h03;
    run_write(7'h0E, 2, 1'b1);
    chk(!scl_oe && !sda_oe, "R1", "released after stop", {scl_oe, sda_oe}, 0);

    // R6: long minimum, core ready at once
    min_stretch = 16'd40; core_lat = 0;
    wr_buf[0] = 8'h5A;
    run_write(7'h0E, 1, 1'b1);

    // R7: slow core, short minimum
    min_stretch = 16'd3; core_lat = 60;
    wr_buf[0] = 8'hE0; wr_buf[1] = 8'hD2; wr_buf[2] = 8'h02;
    run_write(7'h0E, 3, 1'b1);

    // R3: other address
    min_stretch = 16'd0; core_lat = 0;
    run_write(7'h21, 2, 1'b1);

    // R1 R8: write phase, repeated start, read of four bytes
    own_addr = 7'h35;
    tx_src[0] = 8'hD2; tx_src[1] = 8'h02; tx_src[2] = 8'h96; tx_src[3] = 8'h49;
    wr_buf[0] = 8'hA1; wr_buf[1] = 8'h0A;
    run_write(7'h35, 2, 1'b0);
    run_read(7'h35, 4);

    // R1: start cuts a byte short, then a complete write
    m_start();
    m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
    wr_buf[0] = 8'h7F;
    run_write(7'h35, 1, 1'b1);

    // R3 on read
    run_read(7'h11, 2);

    // random traffic
    for (int t = 0; t < 30; t++) begin
      int n;
      logic [6:0] a;
      own_addr = 7'($urandom % 128);
      min_stretch = STR_W'($urandom % 21);
      core_lat = $urandom % 21;
      n = 1 + ($urandom % 6);
      a = (($urandom % 10) < 7) ? own_addr : (own_addr ^ 7'(1 + ($urandom % 127)));
      for (int i = 0; i < 16; i++) begin
        wr_buf[i] = 8'($urandom);
        tx_src[i] = 8'($urandom);
      end
      if ($urandom % 2) run_read(a, n);
      else run_write(a, n, 1'b1);
    end

    chk(bp_viol == 0, "R9", "back-pressure violations", bp_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule